// File: doc/BRIEF.md
# Scatter-Gather Descriptor DMA Engine

This engine moves a stream of bytes between a local sector buffer and main memory. The memory regions taking part are listed in a table of 8-byte descriptors in memory. A start pulse supplies the table base, the byte count the drive side wants moved, and the direction. The engine then fetches descriptors and issues one 32-bit data beat at a time on a request/grant memory port. It advances the buffer offset as each beat completes.

A run ends in one of three ways. It finishes normally when the requested count has been moved. It finishes short when the descriptor table runs out first, either because a descriptor carried the end flag or because the walk reached the one-page guard. Or an abort input stops it. Each descriptor holds a word-aligned region address, followed by a size word. In the size word, bit 31 marks the final entry and bits 15:1 give the region length in bytes.

Top module: `sgd_dma_engine`

## Requirements
- R1: A start pulse accepted while idle (and with abort low) reloads the descriptor pointer from `table_base` with its two low bits cleared. It also clears the current region address, the region length and the end flag. The first memory access is then a read of the region address word at the pointer, followed by a read of the size word at pointer+4. The next descriptor is read at pointer+8.
- R2: The region length in bytes is the size word ANDed with 0xFFFE. Bit 0 and bits 30:16 have no effect on the length.
- R3: A size word whose bits 15:1 are all zero describes a region of 65536 bytes.
- R4: When the region described by a size word with bit 31 set is used up, no further descriptor is read.
- R5: No descriptor is read once the pointer has advanced 4096 or more bytes past the table base, even if no descriptor carried bit 31.
- R6: Each data beat goes to the current region address, which is word-aligned. A beat moves 4 bytes with byte enables 4'b1111 when at least 4 bytes remain both in the request and in the region. Otherwise it moves 2 bytes with byte enables 4'b0011. After the beat, the region address and the buffer offset advance by the bytes moved. While the grant is low, a pending request holds its address.
- R7: With `dir`=1, data beats are memory writes (`mem_we`=1) carrying `buf_rdata` of the current buffer offset. With `dir`=0, they are memory reads, and the beat's grant cycle writes `mem_rdata` into the buffer with `buf_we`=1 and the beat's byte enables.
- R8: `done` is high for exactly one cycle at the end of a run. In that cycle, `underrun` is 1 if requested bytes were left unmoved. `eot` is 1 if the current region is empty and the table is spent, meaning the end flag has been seen or the page guard has been reached. Neither flag is ever high without `done`.
- R9: When `abort` is high at a clock edge, the engine is idle after that edge. It issues no further memory request and gives no `done` for that run.
- R10: Bit 0 of `xfer_bytes` is ignored. A request of 0 bytes completes with `done` two cycles after start, with no memory access and both flags low.
- R11: A descriptor is fetched only when the current region length is zero. Bytes left in a region after the request is satisfied are not moved. The buffer offset runs on contiguously from one region to the next, starting at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Start pulse, honoured when idle |
| abort | input | 1 | Synchronous abort to idle |
| dir | input | 1 | 1: buffer to memory, 0: memory to buffer |
| table_base | input | ADDR_W | Descriptor table base address |
| xfer_bytes | input | CNT_W | Bytes requested by the drive side |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | Memory write when 1 |
| mem_addr | output | ADDR_W | Word-aligned memory address |
| mem_be | output | 4 | Byte enables of the beat |
| mem_wdata | output | 32 | Write data |
| mem_gnt | input | 1 | Grant; the beat completes in this cycle |
| mem_rdata | input | 32 | Read data, valid with grant |
| buf_addr | output | CNT_W | Byte offset into the sector buffer |
| buf_rdata | input | 32 | Buffer data at `buf_addr`, little-endian |
| buf_we | output | 1 | Buffer write strobe |
| buf_be | output | 4 | Buffer byte enables |
| buf_wdata | output | 32 | Buffer write data |
| busy | output | 1 | Run in progress |
| done | output | 1 | One-cycle completion pulse |
| underrun | output | 1 | Table ended before the count was met |
| eot | output | 1 | Descriptor table exhausted at completion |

## Verification
The properties assume the following about the inputs. Every region address in the table and the table base itself are word-aligned. Read data comes back in the grant cycle. The grant may stay low for any number of cycles. The stimulus builds every table with word-aligned region addresses. It drives the grant from a pseudo-random sequence, except on the 64 KiB run, where the grant is held high to keep the run short. Abort is raised in the middle of a long read run, and a new run follows from a different table base.

// File: rtl/sgd_pkg.sv
package sgd_pkg;

   localparam int unsigned SGD_LEN_W = 17;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_CHECK,
      ST_DESC_LO,
      ST_DESC_HI,
      ST_MOVE,
      ST_END
   } sgd_state_e;

   // Region length from the low half of a size word: bit 0 dropped, zero means 64 KiB.
   function automatic logic [SGD_LEN_W-1:0] sgd_region_len(input logic [15:0] size_lo);
      logic [15:0] masked;
      masked = size_lo & 16'hFFFE;
      return (masked == 16'h0000) ? 17'h10000 : {1'b0, masked};
   endfunction

endpackage

// File: rtl/sgd_walker.sv
module sgd_walker
   import sgd_pkg::*;
#(
   parameter int unsigned ADDR_W     = 32,
   parameter int unsigned PAGE_BYTES = 4096,
   parameter bit          GUARD_EN   = 1'b1
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 load,
   input  logic [ADDR_W-1:0]    base,
   input  logic                 lo_ack,
   input  logic                 hi_ack,
   input  logic                 beat_ack,
   input  logic [2:0]           step,
   input  logic [31:0]          rdata,
   output logic [ADDR_W-1:0]    ptr,
   output logic [ADDR_W-1:0]    region_addr,
   output logic [SGD_LEN_W-1:0] region_len,
   output logic                 region_empty,
   output logic                 table_spent
);

   localparam logic [ADDR_W-1:0] PTR_STEP  = ADDR_W'(4);
   localparam logic [ADDR_W-1:0] GUARD_LIM = ADDR_W'(PAGE_BYTES);

   logic [ADDR_W-1:0] base_q;
   logic              last_q;
   logic              guard_hit;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         base_q      <= '0;
         ptr         <= '0;
         region_addr <= '0;
         region_len  <= '0;
         last_q      <= 1'b0;
      end else if (load) begin
         base_q      <= {base[ADDR_W-1:2], 2'b00};
         ptr         <= {base[ADDR_W-1:2], 2'b00};
         region_addr <= '0;
         region_len  <= '0;
         last_q      <= 1'b0;
      end else begin
         if (lo_ack) begin
            region_addr <= rdata[ADDR_W-1:0];
            ptr         <= ptr + PTR_STEP;
         end
         if (hi_ack) begin
            region_len <= sgd_region_len(rdata[15:0]);
            last_q     <= rdata[31];
            ptr        <= ptr + PTR_STEP;
         end
         if (beat_ack) begin
            region_addr <= region_addr + ADDR_W'(step);
            region_len  <= region_len - SGD_LEN_W'(step);
         end
      end
   end

   generate
      if (GUARD_EN) begin : g_page_guard
         assign guard_hit = (ptr - base_q) >= GUARD_LIM;
      end else begin : g_no_guard
         assign guard_hit = 1'b0;
      end
   endgenerate

   assign region_empty = (region_len == '0);
   assign table_spent  = last_q | guard_hit;

endmodule

// File: rtl/sgd_beat.sv
module sgd_beat
   import sgd_pkg::*;
#(
   parameter int unsigned CNT_W = 20
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 load,
   input  logic [CNT_W-1:0]     xfer_bytes,
   input  logic                 beat_ack,
   input  logic [SGD_LEN_W-1:0] region_len,
   output logic [2:0]           step,
   output logic [3:0]           be,
   output logic                 rem_zero,
   output logic [CNT_W-1:0]     buf_off
);

   localparam logic [CNT_W-1:0]     REM_WORD = CNT_W'(4);
   localparam logic [SGD_LEN_W-1:0] LEN_WORD = SGD_LEN_W'(4);

   logic [CNT_W-1:0] remaining;
   logic             wide;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         remaining <= '0;
         buf_off   <= '0;
      end else if (load) begin
         remaining <= {xfer_bytes[CNT_W-1:1], 1'b0};
         buf_off   <= '0;
      end else if (beat_ack) begin
         remaining <= remaining - CNT_W'(step);
         buf_off   <= buf_off + CNT_W'(step);
      end
   end

   assign wide     = (remaining >= REM_WORD) && (region_len >= LEN_WORD);
   assign step     = wide ? 3'd4 : 3'd2;
   assign be       = wide ? 4'b1111 : 4'b0011;
   assign rem_zero = (remaining == '0);

endmodule

// File: rtl/sgd_ctrl.sv
module sgd_ctrl
   import sgd_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       start,
   input  logic       abort,
   input  logic       rem_zero,
   input  logic       region_empty,
   input  logic       table_spent,
   input  logic       gnt,
   output sgd_state_e state
);

   sgd_state_e nxt;

   always_comb begin
      nxt = state;
      unique case (state)
         ST_IDLE:    if (start) nxt = ST_CHECK;
         ST_CHECK: begin
            if (rem_zero)          nxt = ST_END;
            else if (!region_empty) nxt = ST_MOVE;
            else if (table_spent)  nxt = ST_END;
            else                   nxt = ST_DESC_LO;
         end
         ST_DESC_LO: if (gnt) nxt = ST_DESC_HI;
         ST_DESC_HI: if (gnt) nxt = ST_CHECK;
         ST_MOVE:    if (gnt) nxt = ST_CHECK;
         ST_END:     nxt = ST_IDLE;
         default:    nxt = ST_IDLE;
      endcase
      if (abort) nxt = ST_IDLE;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) state <= ST_IDLE;
      else        state <= nxt;
   end

endmodule

// File: rtl/sgd_dma_engine.sv
module sgd_dma_engine
   import sgd_pkg::*;
#(
   parameter int unsigned ADDR_W     = 32,
   parameter int unsigned CNT_W      = 20,
   parameter int unsigned PAGE_BYTES = 4096,
   parameter bit          GUARD_EN   = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic              abort,
   input  logic              dir,
   input  logic [ADDR_W-1:0] table_base,
   input  logic [CNT_W-1:0]  xfer_bytes,
   output logic              mem_req,
   output logic              mem_we,
   output logic [ADDR_W-1:0] mem_addr,
   output logic [3:0]        mem_be,
   output logic [31:0]       mem_wdata,
   input  logic              mem_gnt,
   input  logic [31:0]       mem_rdata,
   output logic [CNT_W-1:0]  buf_addr,
   input  logic [31:0]       buf_rdata,
   output logic              buf_we,
   output logic [3:0]        buf_be,
   output logic [31:0]       buf_wdata,
   output logic              busy,
   output logic              done,
   output logic              underrun,
   output logic              eot
);

   generate
      if (ADDR_W < 13 || ADDR_W > 32) begin : g_bad_addr_w
         $error("ADDR_W must lie between 13 and 32");
      end
      if (CNT_W < 3) begin : g_bad_cnt_w
         $error("CNT_W must be at least 3");
      end
      if ((PAGE_BYTES % 8) != 0 || PAGE_BYTES == 0) begin : g_bad_page
         $error("PAGE_BYTES must be a nonzero multiple of the descriptor size");
      end
   endgenerate

   sgd_state_e           state;
   logic                 load, lo_ack, hi_ack, beat_ack;
   logic                 in_lo, in_hi, in_move;
   logic                 dir_q;
   logic [2:0]           step;
   logic [3:0]           beat_be;
   logic                 rem_zero, region_empty, table_spent;
   logic [ADDR_W-1:0]    ptr, region_addr;
   logic [SGD_LEN_W-1:0] region_len;

   assign in_lo    = (state == ST_DESC_LO);
   assign in_hi    = (state == ST_DESC_HI);
   assign in_move  = (state == ST_MOVE);
   assign load     = (state == ST_IDLE) && start && !abort;
   assign lo_ack   = in_lo && mem_gnt;
   assign hi_ack   = in_hi && mem_gnt;
   assign beat_ack = in_move && mem_gnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    dir_q <= 1'b0;
      else if (load) dir_q <= dir;
   end

   sgd_ctrl i_ctrl (
      .clk          (clk),
      .rst_n        (rst_n),
      .start        (start),
      .abort        (abort),
      .rem_zero     (rem_zero),
      .region_empty (region_empty),
      .table_spent  (table_spent),
      .gnt          (mem_gnt),
      .state        (state)
   );

   sgd_walker #(
      .ADDR_W     (ADDR_W),
      .PAGE_BYTES (PAGE_BYTES),
      .GUARD_EN   (GUARD_EN)
   ) i_walker (
      .clk          (clk),
      .rst_n        (rst_n),
      .load         (load),
      .base         (table_base),
      .lo_ack       (lo_ack),
      .hi_ack       (hi_ack),
      .beat_ack     (beat_ack),
      .step         (step),
      .rdata        (mem_rdata),
      .ptr          (ptr),
      .region_addr  (region_addr),
      .region_len   (region_len),
      .region_empty (region_empty),
      .table_spent  (table_spent)
   );

   sgd_beat #(
      .CNT_W (CNT_W)
   ) i_beat (
      .clk        (clk),
      .rst_n      (rst_n),
      .load       (load),
      .xfer_bytes (xfer_bytes),
      .beat_ack   (beat_ack),
      .region_len (region_len),
      .step       (step),
      .be         (beat_be),
      .rem_zero   (rem_zero),
      .buf_off    (buf_addr)
   );

   assign mem_req   = in_lo || in_hi || in_move;
   assign mem_we    = in_move && dir_q;
   assign mem_addr  = in_move ? region_addr : ptr;
   assign mem_be    = in_move ? beat_be : 4'b1111;
   assign mem_wdata = mem_we ? buf_rdata : 32'h0;

   assign buf_we    = beat_ack && !dir_q;
   assign buf_be    = beat_be;
   assign buf_wdata = mem_rdata;

   assign busy      = (state != ST_IDLE);
   assign done      = (state == ST_END);
   assign underrun  = done && !rem_zero;
   assign eot       = done && region_empty && table_spent;

endmodule

// File: rtl/sgd_engine_chk.sv
module sgd_engine_chk #(
   parameter int unsigned ADDR_W = 32
) (
   input logic              clk,
   input logic              rst_n,
   input logic              abort,
   input logic              mem_req,
   input logic              mem_gnt,
   input logic              mem_we,
   input logic [ADDR_W-1:0] mem_addr,
   input logic [3:0]        mem_be,
   input logic              buf_we,
   input logic              busy,
   input logic              done,
   input logic              underrun,
   input logic              eot
);

   AST_REQ_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && !mem_gnt && !abort) |=> (mem_req && $stable(mem_addr) && $stable(mem_we))); // R6
   AST_WORD_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req |-> (mem_addr[1:0] == 2'b00)); // R6
   AST_BE_SHAPE: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req |-> (mem_be == 4'b1111 || mem_be == 4'b0011)); // R6
   AST_BUF_WRITE_ON_READ: assert property (@(posedge clk) disable iff (!rst_n)
      buf_we |-> (mem_req && mem_gnt && !mem_we)); // R7
   AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done); // R8
   AST_FLAGS_NEED_DONE: assert property (@(posedge clk) disable iff (!rst_n)
      (underrun || eot) |-> done); // R8
   AST_ABORT_IDLES: assert property (@(posedge clk) disable iff (!rst_n)
      abort |=> (!busy && !done)); // R9
   AST_IDLE_NO_REQ: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> !mem_req); // R9

endmodule

bind sgd_dma_engine sgd_engine_chk #(.ADDR_W(ADDR_W)) i_sgd_engine_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .abort    (abort),
   .mem_req  (mem_req),
   .mem_gnt  (mem_gnt),
   .mem_we   (mem_we),
   .mem_addr (mem_addr),
   .mem_be   (mem_be),
   .buf_we   (buf_we),
   .busy     (busy),
   .done     (done),
   .underrun (underrun),
   .eot      (eot)
);

// File: tb/test_sgd_dma_engine.sv
module test_sgd_dma_engine;

   localparam int unsigned AW = 32;
   localparam int unsigned CW = 20;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          start = 1'b0;
   logic          abort = 1'b0;
   logic          dir = 1'b0;
   logic [AW-1:0] table_base = '0;
   logic [CW-1:0] xfer_bytes = '0;
   logic          mem_req, mem_we;
   logic [AW-1:0] mem_addr;
   logic [3:0]    mem_be;
   logic [31:0]   mem_wdata;
   logic          mem_gnt = 1'b0;
   logic [31:0]   mem_rdata;
   logic [CW-1:0] buf_addr;
   logic [31:0]   buf_rdata;
   logic          buf_we;
   logic [3:0]    buf_be;
   logic [31:0]   buf_wdata;
   logic          busy, done, underrun, eot;

   always #2 clk = ~clk;

   typedef struct {
      logic [31:0] addr;
      logic        we;
      logic [3:0]  be;
      logic [31:0] data;
      logic        is_data;
      int unsigned off;
   } beat_t;

   beat_t       exp_q[$];
   logic [31:0] tbl [0:1023];
   int          n_chk = 0;
   int          n_fail = 0;
   bit          rand_gnt = 1'b1;
   logic [15:0] lfsr = 16'hACE1;

   function automatic logic [31:0] mem_pat(input logic [31:0] a);
      return {a[15:0] + 16'h1234, ~a[15:0]};
   endfunction

   function automatic logic [31:0] buf_pat(input logic [31:0] o);
      return {o[15:0] ^ 16'h5A5A, o[15:0] + 16'h0101};
   endfunction

   function automatic logic [31:0] be_mask(input logic [3:0] be);
      return {{8{be[3]}}, {8{be[2]}}, {8{be[1]}}, {8{be[0]}}};
   endfunction

   always_comb begin
      if (mem_addr[31:28] == 4'h1) mem_rdata = tbl[mem_addr[11:2]];
      else                         mem_rdata = mem_pat(mem_addr);
   end
   assign buf_rdata = buf_pat({12'h0, buf_addr});

   sgd_dma_engine i_sgd_dma_engine (
      .clk(clk), .rst_n(rst_n), .start(start), .abort(abort), .dir(dir),
      .table_base(table_base), .xfer_bytes(xfer_bytes),
      .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_be(mem_be),
      .mem_wdata(mem_wdata), .mem_gnt(mem_gnt), .mem_rdata(mem_rdata),
      .buf_addr(buf_addr), .buf_rdata(buf_rdata), .buf_we(buf_we), .buf_be(buf_be),
      .buf_wdata(buf_wdata), .busy(busy), .done(done), .underrun(underrun), .eot(eot)
   );

   task automatic chk(input bit ok, input string req, input string what,
                      input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
      end
   endtask

   // Grant driver: pseudo-random or always high
   initial forever begin
      @(posedge clk);
      #1;
      lfsr    = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      mem_gnt = rand_gnt ? lfsr[0] : 1'b1;
   end

   // Monitor: pops one expected beat per completed memory handshake
   initial forever begin
      beat_t it;
      logic [31:0] m;
      @(negedge clk);
      if (rst_n && mem_req && mem_gnt) begin
         if (exp_q.size() == 0) begin
            chk(1'b0, "R11", "unexpected memory beat", {32'h0, mem_addr}, 64'h0);
         end else begin
            it = exp_q.pop_front();
            m  = be_mask(it.be);
            chk(mem_addr == it.addr && mem_we == it.we && mem_be == it.be,
                it.is_data ? "R6" : "R1", "beat address/kind",
                {27'h0, mem_we, mem_be, mem_addr}, {27'h0, it.we, it.be, it.addr});
            if (!it.is_data) begin
               chk(!buf_we, "R1", "no buffer write on fetch", {63'h0, buf_we}, 64'h0);
            end else if (it.we) begin
               chk((mem_wdata & m) == (it.data & m) && !buf_we, "R7", "memory write data",
                   {31'h0, buf_we, mem_wdata & m}, {32'h0, it.data & m});
            end else begin
               chk(buf_we && buf_be == it.be && buf_addr == CW'(it.off)
                   && (buf_wdata & m) == (it.data & m), "R7", "buffer write",
                   {7'h0, buf_we, buf_be, buf_addr, buf_wdata & m},
                   {8'h1, it.be, CW'(it.off), it.data & m});
            end
         end
      end
   end

   // Reference walk built from the requirements
   task automatic model(input logic [31:0] base, input int unsigned count, input bit d,
                        output bit eu, output bit ee);
      logic [31:0] ptr, raddr, sz, p4;
      int unsigned rem, rlen, off, st;
      bit          last;
      beat_t       b;
      ptr = {base[31:2], 2'b00}; rem = count & ~32'd1; rlen = 0; raddr = 0; last = 0; off = 0;
      while (rem != 0) begin
         if (rlen == 0) begin
            if (last || (ptr - {base[31:2], 2'b00}) >= 32'd4096) break;
            b = '{ptr, 1'b0, 4'hF, 32'h0, 1'b0, 0};
            exp_q.push_back(b);
            raddr = tbl[ptr[11:2]];
            p4 = ptr + 32'd4;
            b.addr = p4;
            exp_q.push_back(b);
            sz = tbl[p4[11:2]];
            rlen = sz & 32'h0000_FFFE;
            if (rlen == 0) rlen = 65536;
            last = sz[31];
            ptr = ptr + 32'd8;
         end else begin
            st = (rem >= 4 && rlen >= 4) ? 4 : 2;
            b.addr = raddr; b.we = d; b.be = (st == 4) ? 4'hF : 4'h3;
            b.is_data = 1'b1; b.off = off;
            b.data = d ? buf_pat(off) : mem_pat(raddr);
            exp_q.push_back(b);
            raddr += st; rlen -= st; rem -= st; off += st;
         end
      end
      eu = (rem != 0);
      ee = (rlen == 0) && (last || (ptr - {base[31:2], 2'b00}) >= 32'd4096);
   endtask

   task automatic clear_tbl();
      for (int i = 0; i < 1024; i++) tbl[i] = 32'h0;
   endtask

   task automatic set_desc(input int idx, input logic [31:0] a, input logic [31:0] s);
      tbl[2*idx]   = a;
      tbl[2*idx+1] = s;
   endtask

   task automatic kick(input logic [31:0] base, input int unsigned count, input bit d);
      @(posedge clk); #1;
      table_base = base; xfer_bytes = CW'(count); dir = d; start = 1'b1;
      @(posedge clk); #1;
      start = 1'b0;
   endtask

   task automatic run_case(input string tag, input logic [31:0] base,
                           input int unsigned count, input bit d);
      bit eu, ee;
      int unsigned cyc;
      model(base, count, d, eu, ee);
      kick(base, count, d);
      cyc = 0;
      @(negedge clk);
      while (!done && cyc < 100000) begin
         @(negedge clk);
         cyc++;
      end
      chk(done, tag, "run completes", {63'h0, done}, 64'h1);
      chk(underrun == eu, tag, "underrun flag", {63'h0, underrun}, {63'h0, eu});
      chk(eot == ee, tag, "end-of-table flag", {63'h0, eot}, {63'h0, ee});
      chk(exp_q.size() == 0, tag, "all expected beats seen", 64'(exp_q.size()), 64'h0);
      exp_q.delete();
      @(negedge clk);
      chk(!done && !busy, "R8", "done lasts one cycle", {62'h0, done, busy}, 64'h0);
   endtask

   // Watchdog
   initial begin
      repeat (190000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      bit seen_done;
      int req_after;
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      @(negedge clk);
      chk(!busy && !done && !mem_req && !underrun && !eot, "R9", "reset state idle",
          {59'h0, busy, done, mem_req, underrun, eot}, 64'h0);

      // R11: two regions, read direction, exact fit
      clear_tbl();
      set_desc(0, 32'h2000_0000, 32'h0000_000C);
      set_desc(1, 32'h2000_1000, 32'h8000_0006);
      run_case("R11", 32'h1000_0000, 18, 1'b0);

      // R7: same table, write direction
      run_case("R7", 32'h1000_0000, 18, 1'b1);

      // R2: size word with bit 0 and upper junk set gives 6 bytes
      clear_tbl();
      set_desc(0, 32'h2000_0200, 32'h8001_0007);
      run_case("R2", 32'h1000_0000, 100, 1'b0);

      // R4: end flag stops the walk although the next slot holds a descriptor
      clear_tbl();
      set_desc(0, 32'h2000_0300, 32'h8000_0008);
      set_desc(1, 32'h2000_0400, 32'h0000_0010);
      run_case("R4", 32'h1000_0000, 20, 1'b1);

      // R11: request satisfied mid-region, rest left unused
      clear_tbl();
      set_desc(0, 32'h2000_0500, 32'h8000_0010);
      run_case("R11", 32'h1000_0000, 8, 1'b0);

      // R10: zero request and odd request
      run_case("R10", 32'h1000_0000, 0, 1'b0);
      run_case("R10", 32'h1000_0000, 9, 1'b1);

      // R5: 512 unterminated descriptors of 2 bytes, page guard ends the walk
      clear_tbl();
      for (int i = 0; i < 512; i++) set_desc(i, 32'h2100_0000 + 32'(i) * 16, 32'h0000_0002);
      run_case("R5", 32'h1000_0000, 2000, 1'b0);

      // R3: zero-length field means 64 KiB
      rand_gnt = 1'b0;
      clear_tbl();
      set_desc(0, 32'h3000_0000, 32'h0000_0000);
      set_desc(1, 32'h3100_0000, 32'h8000_0004);
      run_case("R3", 32'h1000_0000, 65540, 1'b0);
      rand_gnt = 1'b1;

      // R9: abort in the middle of a long run
      clear_tbl();
      set_desc(0, 32'h4000_0000, 32'h8000_0000);
      begin
         bit eu, ee;
         model(32'h1000_0000, 40000, 1'b0, eu, ee);
      end
      kick(32'h1000_0000, 40000, 1'b0);
      seen_done = 1'b0;
      repeat (60) begin
         @(negedge clk);
         if (done) seen_done = 1'b1;
      end
      @(posedge clk); #1 abort = 1'b1;
      @(posedge clk); #1 abort = 1'b0;
      @(negedge clk);
      chk(!busy && !seen_done, "R9", "idle after abort, no done",
          {62'h0, busy, seen_done}, 64'h0);
      req_after = 0;
      repeat (10) begin
         @(negedge clk);
         if (mem_req || done) req_after++;
      end
      chk(req_after == 0, "R9", "quiet after abort", 64'(req_after), 64'h0);
      exp_q.delete();

      // R1: new run from another base starts with a fresh fetch there
      clear_tbl();
      set_desc(32, 32'h2000_2000, 32'h8000_0008);
      run_case("R1", 32'h1000_0102, 8, 1'b0);

      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

endmodule